// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits beside one processor and decides which single interrupt, if any, is offered to it. It keeps a 32-bit control word made of the processor's current priority threshold (top byte) and the number of the source now pending (low 24 bits), together with the priority of that pending source and a separate priority for the inter-processor interrupt (IPI). Lower numbers are more urgent; 0xFF is the least urgent value and means "off".

A source controller offers requests (source number plus priority). Each one is either taken into the one pending slot, displacing a less urgent occupant, or bounced back as a reject pulse so the source can retry later. The processor side issues register operations: set the priority threshold, set the IPI priority, accept (read and acknowledge), poll, and end-of-interrupt. The block drives the interrupt line and emits reject, end-of-interrupt and resend pulses toward the sources. All results appear on registered outputs one clock after the operation or request is taken.

Top module: `irq_presenter`

## Requirements
- R1: After reset the control word reads 0, the IPI priority reads 0xFF, the pending priority is 0xFF and the interrupt line is low.
- R2: Operation codes on `op_code` are 0 set threshold (from `op_data[7:0]`), 1 set IPI priority (from `op_data[7:0]`), 2 accept, 3 poll, 4 end-of-interrupt; codes 5 to 7 change nothing. Poll returns the control word on `rd_word` (threshold in bits 31:24, pending source in bits 23:0, zero meaning none) and the IPI priority on `rd_ipi`, with `rd_valid` high, and changes no state.
- R3: A request is rejected (reject pulse with its own number) when its priority is not below the threshold, or when a source is pending whose priority is at or below the request's; otherwise it is taken (`req_taken` pulse), becomes the pending source with its priority, and the line goes high.
- R4: A taken request that displaces a pending source which came from the source controller pulses a reject carrying the displaced number; a displaced IPI produces no reject.
- R5: Accept returns the control word as it was, lowers the line, loads the pending priority into the threshold, clears the pending source and sets the pending priority to 0xFF.
- R6: When an IPI check runs with an IPI priority below the threshold, the IPI source number (parameter, default 2) becomes pending at the IPI priority and the line goes high, unless a source is already pending at a priority at or below the IPI priority; a displaced controller source is rejected.
- R7: Lowering the threshold value to at or below the pending priority withdraws the pending source: number cleared, pending priority 0xFF, line low, and a reject if it came from the source controller.
- R8: Raising or keeping the threshold value with nothing pending pulses `resend` and runs the IPI check; end-of-interrupt does the same when nothing is pending after its threshold update.
- R9: End-of-interrupt loads the threshold from `op_data[31:24]` and pulses `eoi_valid` with `eoi_src` equal to `op_data[23:0]`.
- R10: At most one action per cycle: while `op_valid` is high `req_ready` is low and the request is neither taken nor rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Register operation present |
| op_code | input | 3 | Operation selector |
| op_data | input | 32 | Operation write value |
| req_valid | input | 1 | Presentation request present |
| req_src | input | 24 | Requesting source number (non-zero) |
| req_prio | input | 8 | Requesting source priority |
| req_ready | output | 1 | Request can be handled this cycle |
| req_taken | output | 1 | Pulse: last request entered the pending slot |
| rd_valid | output | 1 | Pulse: read result of accept or poll |
| rd_word | output | 32 | Control word returned |
| rd_ipi | output | 8 | IPI priority returned |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Pulse: reject notification |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | Pulse: end-of-interrupt notification |
| eoi_src | output | 24 | Source number finished |
| resend | output | 1 | Pulse: ask sources to re-offer rejected requests |

## Verification
A corrupted pending slot or threshold shows up at the very next poll as a wrong `rd_word`, and in the same cycle as a wrong level on `irq_out` or a missing or extra reject pulse. A wrong IPI priority is visible on `rd_ipi` immediately and on the line the first time an IPI check runs. The bench therefore polls after every operation of a long pseudo-random stream and compares every output each cycle, so any divergence is caught within two clocks of its cause.

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  input  logic [2:0]              op_code,
  input  logic [SRC_W+PRIO_W-1:0] op_data,
  input  logic                    req_valid,
  input  logic [SRC_W-1:0]        req_src,
  input  logic [PRIO_W-1:0]       req_prio,
  output logic                    req_ready,
  output logic                    req_taken,
  output logic                    rd_valid,
  output logic [SRC_W+PRIO_W-1:0] rd_word,
  output logic [PRIO_W-1:0]       rd_ipi,
  output logic                    irq_out,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    resend
);
  localparam int WORD_W = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] P_OFF = '1;
  localparam logic [SRC_W-1:0]  S_NONE = '0;
  localparam logic [SRC_W-1:0]  S_IPI = SRC_W'(IPI_SRC);
  localparam logic [2:0] OP_THR = 3'd0, OP_IPI = 3'd1, OP_ACC = 3'd2,
                         OP_POLL = 3'd3, OP_EOI = 3'd4;

  logic [PRIO_W-1:0] thr, pprio, ipri;
  logic [SRC_W-1:0]  psrc;
  logic              ext;

  logic [PRIO_W-1:0] n_thr, n_pprio, n_ipri;
  logic [SRC_W-1:0]  n_psrc, n_rej_src, n_eoi_src;
  logic              n_ext, n_irq, n_rej, n_eoi, n_resend, n_taken, n_rd, ipi_chk;

  assign req_ready = !op_valid;

  always_comb begin
    n_thr = thr; n_pprio = pprio; n_ipri = ipri; n_psrc = psrc; n_ext = ext;
    n_irq = irq_out; n_rej = 1'b0; n_rej_src = '0; n_eoi = 1'b0; n_eoi_src = '0;
    n_resend = 1'b0; n_taken = 1'b0; n_rd = 1'b0; ipi_chk = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_THR: begin
          n_thr = op_data[PRIO_W-1:0];
          if (n_thr < thr) begin
            if (psrc != S_NONE && n_thr <= pprio) begin
              n_rej = ext; n_rej_src = ext ? psrc : '0;
              n_psrc = S_NONE; n_pprio = P_OFF; n_irq = 1'b0; n_ext = 1'b0;
            end
          end else if (psrc == S_NONE) begin
            n_resend = 1'b1;
            ipi_chk = ipri < n_thr;
          end
        end
        OP_IPI: begin
          n_ipri = op_data[PRIO_W-1:0];
          ipi_chk = n_ipri < thr;
        end
        OP_ACC: begin
          n_rd = 1'b1; n_irq = 1'b0; n_thr = pprio;
          n_psrc = S_NONE; n_pprio = P_OFF; n_ext = 1'b0;
        end
        OP_POLL: n_rd = 1'b1;
        OP_EOI: begin
          n_thr = op_data[WORD_W-1:SRC_W];
          n_eoi = 1'b1; n_eoi_src = op_data[SRC_W-1:0];
          if (psrc == S_NONE) begin
            n_resend = 1'b1;
            ipi_chk = ipri < n_thr;
          end
        end
        default: ;
      endcase
    end else if (req_valid) begin
      if (req_prio >= thr || (psrc != S_NONE && pprio <= req_prio)) begin
        n_rej = 1'b1; n_rej_src = req_src;
      end else begin
        n_rej = psrc != S_NONE && ext; n_rej_src = n_rej ? psrc : '0;
        n_psrc = req_src; n_pprio = req_prio; n_ext = 1'b1;
        n_irq = 1'b1; n_taken = 1'b1;
      end
    end
    if (ipi_chk && !(n_psrc != S_NONE && n_pprio <= n_ipri)) begin
      if (n_psrc != S_NONE && n_ext) begin
        n_rej = 1'b1; n_rej_src = n_psrc;
      end
      n_psrc = S_IPI; n_pprio = n_ipri; n_ext = 1'b0; n_irq = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr <= '0; psrc <= S_NONE; pprio <= P_OFF; ipri <= P_OFF; ext <= 1'b0;
      irq_out <= 1'b0; rej_valid <= 1'b0; rej_src <= '0; eoi_valid <= 1'b0;
      eoi_src <= '0; resend <= 1'b0; req_taken <= 1'b0; rd_valid <= 1'b0;
      rd_word <= '0; rd_ipi <= '0;
    end else begin
      thr <= n_thr; psrc <= n_psrc; pprio <= n_pprio; ipri <= n_ipri; ext <= n_ext;
      irq_out <= n_irq; rej_valid <= n_rej; rej_src <= n_rej_src;
      eoi_valid <= n_eoi; eoi_src <= n_eoi_src; resend <= n_resend;
      req_taken <= n_taken; rd_valid <= n_rd;
      if (n_rd) begin
        rd_word <= {thr, psrc};
        rd_ipi  <= ipri;
      end
    end
  end

  AST_LINE_MATCHES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (psrc != S_NONE)); // R3

  AST_REJECT_LEAVES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_prio >= thr
    |=> rej_valid && rej_src == $past(req_src) && $stable(psrc) && !req_taken); // R3

  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_ACC
    |=> !irq_out && psrc == S_NONE && pprio == P_OFF && rd_valid); // R5

  AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_POLL
    |=> $stable(thr) && $stable(psrc) && $stable(ipri) && $stable(irq_out) && !rej_valid); // R2

  AST_IPI_HIGH_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_IPI && op_data[PRIO_W-1:0] >= thr
    |=> $stable(psrc) && $stable(irq_out) && !rej_valid); // R6

  AST_EOI_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_EOI
    |=> eoi_valid && eoi_src == $past(op_data[SRC_W-1:0])); // R9

  AST_OP_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code != OP_EOI && op_code != OP_THR && op_code != OP_IPI
    |=> !req_taken); // R10
endmodule

// File: tb/irq_presenter_tb.sv
module irq_presenter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic        req_valid = 1'b0;
  logic [23:0] req_src = '0;
  logic [7:0]  req_prio = '0;
  logic        req_ready, req_taken, rd_valid, irq_out, rej_valid, eoi_valid, resend;
  logic [31:0] rd_word;
  logic [7:0]  rd_ipi;
  logic [23:0] rej_src, eoi_src;

  irq_presenter u_dut (.*);

  always #2.5 clk = ~clk;

  int vec = 0, bad = 0;
  logic [7:0]  m_thr, m_pp, m_ipi;
  logic [23:0] m_src;
  logic        m_ext, m_irq;
  logic        e_rej, e_eoi, e_res, e_tak, e_rd, e_ready;
  logic [23:0] e_rej_src, e_eoi_src;
  logic [31:0] e_word;
  logic [7:0]  e_ipi;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic model(input logic opv, input logic [2:0] code, input logic [31:0] d,
                       input logic rqv, input logic [23:0] s, input logic [7:0] p);
    logic ic; logic [7:0] old;
    ic = 0; e_rej = 0; e_rej_src = 0; e_eoi = 0; e_eoi_src = 0; e_res = 0;
    e_tak = 0; e_rd = 0; e_ready = !opv;
    if (opv) begin
      case (code)
        3'd0: begin
          old = m_thr; m_thr = d[7:0];
          if (m_thr < old) begin
            if (m_src != 0 && m_thr <= m_pp) begin
              if (m_ext) begin e_rej = 1; e_rej_src = m_src; end
              m_src = 0; m_pp = 8'hFF; m_irq = 0; m_ext = 0;
            end
          end else if (m_src == 0) begin e_res = 1; ic = m_ipi < m_thr; end
        end
        3'd1: begin m_ipi = d[7:0]; ic = m_ipi < m_thr; end
        3'd2: begin
          e_rd = 1; e_word = {m_thr, m_src}; e_ipi = m_ipi;
          m_irq = 0; m_thr = m_pp; m_src = 0; m_pp = 8'hFF; m_ext = 0;
        end
        3'd3: begin e_rd = 1; e_word = {m_thr, m_src}; e_ipi = m_ipi; end
        3'd4: begin
          m_thr = d[31:24]; e_eoi = 1; e_eoi_src = d[23:0];
          if (m_src == 0) begin e_res = 1; ic = m_ipi < m_thr; end
        end
        default: ;
      endcase
    end else if (rqv) begin
      if (p >= m_thr || (m_src != 0 && m_pp <= p)) begin
        e_rej = 1; e_rej_src = s;
      end else begin
        if (m_src != 0 && m_ext) begin e_rej = 1; e_rej_src = m_src; end
        m_src = s; m_pp = p; m_ext = 1; m_irq = 1; e_tak = 1;
      end
    end
    if (ic && !(m_src != 0 && m_pp <= m_ipi)) begin
      if (m_src != 0 && m_ext) begin e_rej = 1; e_rej_src = m_src; end
      m_src = 24'd2; m_pp = m_ipi; m_ext = 0; m_irq = 1;
    end
  endtask

  task automatic step(input string tag, input logic opv, input logic [2:0] code,
                      input logic [31:0] d, input logic rqv, input logic [23:0] s,
                      input logic [7:0] p);
    model(opv, code, d, rqv, s, p);
    op_valid = opv; op_code = code; op_data = d;
    req_valid = rqv; req_src = s; req_prio = p;
    #1;
    chk({tag, " R10 ready"}, 32'(req_ready), 32'(e_ready));
    @(posedge clk); #1;
    op_valid = 0; req_valid = 0;
    chk({tag, " line"}, 32'(irq_out), 32'(m_irq));
    chk({tag, " R4 rej"}, 32'(rej_valid), 32'(e_rej));
    if (e_rej) chk({tag, " R4 rej_src"}, 32'(rej_src), 32'(e_rej_src));
    chk({tag, " R9 eoi"}, 32'(eoi_valid), 32'(e_eoi));
    if (e_eoi) chk({tag, " R9 eoi_src"}, 32'(eoi_src), 32'(e_eoi_src));
    chk({tag, " R8 resend"}, 32'(resend), 32'(e_res));
    chk({tag, " R3 taken"}, 32'(req_taken), 32'(e_tak));
    chk({tag, " R2 rd_valid"}, 32'(rd_valid), 32'(e_rd));
    if (e_rd) begin
      chk({tag, " R2 word"}, rd_word, e_word);
      chk({tag, " R2 ipi"}, 32'(rd_ipi), 32'(e_ipi));
    end
  endtask

  task automatic poll(input string tag);
    step({tag, " poll"}, 1, 3'd3, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    m_thr = 0; m_pp = 8'hFF; m_ipi = 8'hFF; m_src = 0; m_ext = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 line after reset", 32'(irq_out), 0);
    poll("R1");

    // R3 sweep: threshold against request priority from an empty slot
    for (int t = 0; t < 9; t++) begin
      for (int q = 0; q < 9; q++) begin
        step("R8 thr set", 1, 3'd0, 32'(t), 0, 0, 0);
        step("R3 sweep req", 0, 0, 0, 1, 24'(q + 5), 8'(q));
        chk("R3 sweep arith", 32'(req_taken), 32'(q < t));
        step("R5 accept", 1, 3'd2, 0, 0, 0, 0);
      end
    end

    // R4 displacement and R7 withdrawal, R6 IPI
    step("R8 open", 1, 3'd0, 32'hFF, 0, 0, 0);
    step("R3 first", 0, 0, 0, 1, 24'd9, 8'd6);
    step("R4 displace", 0, 0, 0, 1, 24'd11, 8'd3);
    chk("R4 displaced number", 32'(rej_src), 32'd9);
    step("R6 ipi wins", 1, 3'd1, 32'd1, 0, 0, 0);
    poll("R6");
    chk("R6 ipi source pending", rd_word, {8'hFF, 24'd2});
    step("R7 withdraw", 1, 3'd0, 32'd1, 0, 0, 0);
    poll("R7");
    step("R2 unused code", 1, 3'd6, 32'h12, 0, 0, 0);
    step("R10 both", 1, 3'd3, 0, 1, 24'd7, 8'd0);

    // pseudo-random stream, polled after each operation
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] p; logic [23:0] s; logic [2:0] k;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      p = (lf[2:0] == 3'd7) ? 8'hFF : 8'(lf[2:0]);
      s = 24'(lf[5:3] % 5) + 24'd1;
      k = lf[8:6];
      case (k)
        3'd0, 3'd1, 3'd2: step("R3 rnd req", 0, 0, 0, 1, s, p);
        3'd3: step("R7 rnd thr", 1, 3'd0, 32'(p), lf[9], s, p);
        3'd4: step("R6 rnd ipi", 1, 3'd1, 32'(p), 0, 0, 0);
        3'd5: step("R5 rnd acc", 1, 3'd2, 0, lf[9], s, p);
        3'd6: step("R9 rnd eoi", 1, 3'd4, {p, s}, 0, 0, 0);
        default: step("R2 rnd odd", 1, 3'd7, 32'(p), 0, 0, 0);
      endcase
      poll("R2 rnd");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule